// File: doc/BRIEF.md
# Control-OUT Endpoint Receive Buffer

This block stores the data-stage OUT packets that arrive on a USB control endpoint. Setup packets are not stored here. The serial engine delivers each packet as a byte stream in three steps. A start strobe opens the packet. A valid strobe comes with each data byte. An end strobe comes on its own cycle and carries a good-status bit. After a good packet the block latches the byte count and pulses a completion event. It then raises a full indication, which tells the engine to answer further OUT tokens with NAK and to write nothing.

Firmware reads the stored bytes one at a time through an 8-bit read-only port. Each read strobe moves to the next byte. When firmware has read the packet, it pulses a read-finished trigger, and the buffer accepts the next packet. A flush input returns the buffer to empty at any time. A packet that ends with bad status leaves no trace. A packet longer than the capacity is treated as errored.

Top module: `ctrl_out_rxbuf`

## Requirements
- R1: After reset, `buf_full` is 0, `rx_size` is 0 and `rx_done` is 0.
- R2: A packet of N bytes (0 to 8) that ends with `rx_good`=1 has these results one cycle after its end strobe: `buf_full`=1, `rx_size`=N, and `rx_done` high for exactly that one cycle.
- R3: While full, `cpu_rdata` shows the stored byte at the read index. The read index starts at 0 for each accepted packet. Each `cpu_rd` cycle advances it by one, so the bytes come out in arrival order.
- R4: While `buf_full`=1, start, valid and end strobes are ignored. The stored bytes and `rx_size` stay unchanged, and `rx_done` does not pulse.
- R5: A `rd_finish` pulse while full clears `buf_full` on the next cycle. The following packet is then accepted.
- R6: A packet whose end strobe has `rx_good`=0 sets no flag and leaves `buf_full` at 0. `rx_size` keeps its previous value, and the next packet is accepted.
- R7: A packet of more than 8 data bytes is errored. It is not accepted even if it ends with good status: `buf_full` stays 0 and `rx_done` does not pulse.
- R8: A `buf_clear` pulse forces `buf_full`=0 and `rx_size`=0 on the next cycle and abandons any packet in progress. An end strobe that arrives later without a new start strobe completes nothing.
- R9: Valid and end strobes that arrive with no open packet, that is with no start strobe since the last end strobe or clear, are ignored.
- R10: A good packet with zero data bytes is accepted with `rx_size`=0 and `buf_full`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sop | input | 1 | Start of an OUT data packet |
| rx_valid | input | 1 | `rx_data` carries a data byte |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End of packet, on its own cycle |
| rx_good | input | 1 | Status that comes with `rx_eop`; 1 means the packet was received without error |
| buf_full | output | 1 | A packet is held; the engine must NAK |
| rx_done | output | 1 | One-cycle event on good reception |
| rx_size | output | 4 | Byte count of the held packet |
| cpu_rd | input | 1 | Read strobe; advances the read index |
| cpu_rdata | output | 8 | Byte at the current read index |
| rd_finish | input | 1 | Firmware has finished reading; re-arms the buffer |
| buf_clear | input | 1 | Flushes the buffer |

## Verification
Every registered result appears one clock edge after its cause. `buf_full`, `rx_size` and `rx_done` follow the end strobe, `rd_finish` or `buf_clear` by one cycle. `cpu_rdata` changes one cycle after each `cpu_rd`, because the read index is the only register in its path. The bench drives stimulus on falling edges and samples on the next falling edge, which is exactly one rising edge later. It also checks `rx_done` on the following falling edge to confirm that the event lasts one cycle.

// File: rtl/ctrl_out_rxbuf.sv
module ctrl_out_rxbuf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_sop,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_eop,
  input  logic          rx_good,
  output logic          buf_full,
  output logic          rx_done,
  output logic [CW-1:0] rx_size,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          rd_finish,
  input  logic          buf_clear
);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wcnt;
  logic [AW-1:0] rptr;
  logic          open_q, err_q;

  wire   room    = (wcnt < CW'(DEPTH));
  wire   take    = !buf_full && open_q && !rx_sop && rx_valid;
  wire   wr_byte = take && room && !buf_clear;

  assign cpu_rdata = mem[rptr];

  always_ff @(posedge clk)
    if (wr_byte) mem[wcnt[AW-1:0]] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n || buf_clear) begin
      open_q   <= 1'b0;
      err_q    <= 1'b0;
      wcnt     <= '0;
      rptr     <= '0;
      buf_full <= 1'b0;
      rx_done  <= 1'b0;
      rx_size  <= '0;
    end else begin
      rx_done <= 1'b0;
      if (rd_finish) begin
        buf_full <= 1'b0;
        rptr     <= '0;
      end else if (cpu_rd && buf_full) begin
        rptr <= rptr + 1'b1;
      end
      if (!buf_full) begin
        if (rx_sop) begin
          open_q <= 1'b1;
          err_q  <= 1'b0;
          wcnt   <= '0;
        end else if (take) begin
          if (room) wcnt  <= wcnt + 1'b1;
          else      err_q <= 1'b1;
        end else if (open_q && rx_eop) begin
          open_q <= 1'b0;
          if (rx_good && !err_q) begin
            buf_full <= 1'b1;
            rx_done  <= 1'b1;
            rx_size  <= wcnt;
            rptr     <= '0;
          end
        end
      end
    end
  end

endmodule

module ctrl_out_rxbuf_chk #(parameter int CW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_eop,
  input logic          rx_good,
  input logic          buf_full,
  input logic          rx_done,
  input logic [CW-1:0] rx_size,
  input logic          rd_finish,
  input logic          buf_clear
);
  a_r2_done_rises_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $rose(buf_full));
  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  a_r4_size_held: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !buf_clear) |=> $stable(rx_size));
  a_r5_finish_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_finish && buf_full && !buf_clear) |=> !buf_full);
  a_r6_bad_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && !rx_good && !buf_full) |=> !rx_done);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> (!buf_full && rx_size == '0 && !rx_done));
endmodule

bind ctrl_out_rxbuf ctrl_out_rxbuf_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_eop(rx_eop), .rx_good(rx_good),
  .buf_full(buf_full), .rx_done(rx_done), .rx_size(rx_size),
  .rd_finish(rd_finish), .buf_clear(buf_clear)
);

// File: tb/sim_ctrl_out_rxbuf.sv
`timescale 1ns/1ps
module sim_ctrl_out_rxbuf;
  logic clk = 0, rst_n = 0;
  logic rx_sop = 0, rx_valid = 0, rx_eop = 0, rx_good = 0;
  logic [7:0] rx_data = 0;
  logic cpu_rd = 0, rd_finish = 0, buf_clear = 0;
  logic buf_full, rx_done;
  logic [3:0] rx_size;
  logic [7:0] cpu_rdata;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ctrl_out_rxbuf u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic send_pkt(int n, int base, bit good);
    rx_sop = 1; step(); rx_sop = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = 8'(base + i); step();
    end
    rx_valid = 0;
    rx_eop = 1; rx_good = good; step();
    rx_eop = 0; rx_good = 0;
  endtask

  task automatic read_expect(string req, int n, int base);
    for (int i = 0; i < n; i++) begin
      check(req, cpu_rdata, (base + i) & 8'hff);
      cpu_rd = 1; step(); cpu_rd = 0;
    end
  endtask

  task automatic finish_read();
    rd_finish = 1; step(); rd_finish = 0;
  endtask

  task automatic t_reset();
    check("R1 full", buf_full, 0);
    check("R1 size", rx_size, 0);
    check("R1 done", rx_done, 0);
  endtask

  task automatic t_good();
    send_pkt(5, 8'h10, 1);
    check("R2 full", buf_full, 1);
    check("R2 size", rx_size, 5);
    check("R2 done", rx_done, 1);
    step();
    check("R2 done one cycle", rx_done, 0);
    read_expect("R3 data", 5, 8'h10);
    finish_read();
    check("R5 full cleared", buf_full, 0);
  endtask

  task automatic t_full_ignore();
    send_pkt(3, 8'h20, 1);
    send_pkt(6, 8'h40, 1);
    check("R4 no done", rx_done, 0);
    check("R4 size", rx_size, 3);
    check("R4 full", buf_full, 1);
    read_expect("R4 data kept", 3, 8'h20);
    finish_read();
  endtask

  task automatic t_bad();
    send_pkt(4, 8'h60, 0);
    check("R6 full", buf_full, 0);
    check("R6 done", rx_done, 0);
    check("R6 size kept", rx_size, 3);
    send_pkt(2, 8'h70, 1);
    check("R6 next accepted", buf_full, 1);
    check("R6 next size", rx_size, 2);
    read_expect("R6 data", 2, 8'h70);
    finish_read();
    check("R5 full cleared", buf_full, 0);
  endtask

  task automatic t_overflow();
    send_pkt(9, 8'h80, 1);
    check("R7 full", buf_full, 0);
    check("R7 done", rx_done, 0);
    send_pkt(8, 8'hA0, 1);
    check("R2 max full", buf_full, 1);
    check("R2 max size", rx_size, 8);
    read_expect("R3 max data", 8, 8'hA0);
    finish_read();
  endtask

  task automatic t_zero();
    send_pkt(0, 0, 1);
    check("R10 full", buf_full, 1);
    check("R10 size", rx_size, 0);
    check("R10 done", rx_done, 1);
    finish_read();
  endtask

  task automatic t_clear();
    send_pkt(4, 8'hB0, 1);
    read_expect("R3 before clear", 1, 8'hB0);
    buf_clear = 1; step(); buf_clear = 0;
    check("R8 full", buf_full, 0);
    check("R8 size", rx_size, 0);
    rx_sop = 1; step(); rx_sop = 0;
    rx_valid = 1; rx_data = 8'h01; step();
    rx_data = 8'h02; step(); rx_valid = 0;
    buf_clear = 1; step(); buf_clear = 0;
    rx_eop = 1; rx_good = 1; step(); rx_eop = 0; rx_good = 0;
    check("R8 abandoned full", buf_full, 0);
    check("R8 abandoned done", rx_done, 0);
    rx_valid = 1; rx_data = 8'h55; step(); rx_valid = 0;
    rx_eop = 1; rx_good = 1; step(); rx_eop = 0; rx_good = 0;
    check("R9 stray full", buf_full, 0);
    check("R9 stray done", rx_done, 0);
    send_pkt(2, 8'hC0, 1);
    check("R8 after clear size", rx_size, 2);
    read_expect("R3 index restart", 2, 8'hC0);
    finish_read();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_good();
    t_full_ignore();
    t_bad();
    t_overflow();
    t_zero();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule